// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block is the management target of a clock-control chip: a two-wire (SMBus-style) target that gives a host access to an 18-byte control register file. It runs on a fast system clock, oversamples the bus clock and data lines, and finds start and stop conditions and bit edges from the synchronised levels. It pulls the data line low for acknowledges and for read bits, and never drives it high.

The first byte after the address selects the access mode. When its top bit is set, the access is a single-byte access, and the low seven bits give the register index. When its top bit is clear, the access is a block access. A block always starts at register 0. A block write carries a byte count, which the target accepts and discards, and then the data. A block read returns the file size first and then the registers in ascending order. Reads in both modes use a repeated start and a second address phase with the read bit set. Part of the file cannot be changed by writes: a strap field is captured during reset, and a fixed identification nibble holds its value. One status bit is set by a hardware input and cleared when 1 is written to it. Each accepted register write also appears on a strobe with its index and data, so neighbouring logic can act on it.

Top module: `smb_ctrl_regs`

## Requirements
- R1: The target answers only the 7-bit address 0x69 (address byte D2h for write, D3h for read) by pulling data low in the acknowledge slot. For any other address it leaves the acknowledge slot high and then ignores the bus, giving no acknowledge to any later byte, until the next start.
- R2: A command byte with bit 7 = 1 selects single-byte access at index bits 6:0. The next byte is shifted in MSB first and stored at that index. For one clock, `wr_strobe` pulses with `wr_index` equal to the index and `wr_data` equal to the byte.
- R3: Command with bit 7 = 1, then a repeated start and address D3h: the target returns the register at index bits 6:0, MSB first. The host ends the read with a NACK and a stop.
- R4: Command 00h on a write: the next byte is a count and is discarded. The data bytes that follow go to registers 0, 1, 2 and upward. A stop after any whole byte leaves all later registers unchanged.
- R5: Command 00h, then a repeated start and address D3h: the first byte returned is the file size (0x12), followed by registers 0, 1, 2 and upward. The read continues as long as the host acknowledges. After a host NACK the target releases the data line.
- R6: Bits 4:0 of register 1 hold `strap_in` as captured during reset, and bits 3:0 of register 6 hold 8. Writes do not change these bits. The other bits of registers 1 and 6 are writable.
- R7: Bit 2 of register 9 is set by a one-cycle pulse on `alarm_set`. Writing a byte to register 9 with bit 2 = 1 clears it, and writing 0 in bit 2 leaves it unchanged. The other bits of register 9 store the written value.
- R8: Writes to indices 18 and above are acknowledged, change no register and give no strobe. Reads from those indices return 00h.
- R9: After reset: register 1 = E0h with the strap value in bits 4:0, register 2 = 7Fh, 3 = C7h, 4 = 17h, 5 = 01h, 6 = 08h, 8 = 3Eh, 15 = 03h. Every other register is 00h, and the data line is released.
- R10: After a matched address, the target acknowledges every byte it receives in every mode. It changes its data-line drive only while the synchronised bus clock is low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low |
| strap_in | input | 5 | Strap levels captured into register 1 during reset |
| alarm_set | input | 1 | Sets the sticky status bit (register 9, bit 2) |
| wr_strobe | output | 1 | One-cycle pulse for each accepted register write |
| wr_index | output | 7 | Register index of the write |
| wr_data | output | 8 | Byte written by the host |
| regs_out | output | 144 | Current register file, byte i in bits 8i+7:8i |

## Verification
The bench aims at the points where a target usually goes wrong. A block read that forgot to send the count byte would return every register one position early. A block write that stored the count as data would shift the whole file. A repeated start that cleared the command context would read register 0 instead of the chosen index. An address decoder that rechecked later bytes after a mismatch would start acknowledging traffic meant for another device. The bench also writes all-ones and all-zeros to the protected fields and the write-one-to-clear bit, and writes past the end of the file. A masking mistake there would show up as changed strap or identification bits, a status bit that sets or clears on the wrong value, or a strobe or read-back from a register that does not exist.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int PTR_W     = 7;
    localparam int STRAP_REG = 1;
    localparam int IDENT_REG = 6;
    localparam int STAT_REG  = 9;
    localparam int STAT_BIT  = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_CNT,
        S_CNT_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RDAT_MACK,
        S_HOLD
    } tgt_state_t;

    typedef struct packed {
        logic             blk;
        logic [PTR_W-1:0] ptr;
    } xfer_ctx_t;

    typedef struct packed {
        logic             stb;
        logic [PTR_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            1:       return 8'hE0;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h17;
            5:       return 8'h01;
            6:       return 8'h08;
            8:       return 8'h3E;
            15:      return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] ro_mask(input int idx);
        if (idx == STRAP_REG) return 8'h1F;
        if (idx == IDENT_REG) return 8'h0F;
        return 8'h00;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == {PTR_W{1'b1}}) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    localparam int SYNC_STAGES = 2;

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_lvl  = scl_q[SYNC_STAGES-1];
    assign sda_lvl  = sda_q[SYNC_STAGES-1];
    assign ev_rise  = scl_lvl & ~scl_d;
    assign ev_fall  = ~scl_lvl & scl_d;
    assign ev_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign ev_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smbreg_pkg::*;
#(
    parameter int               NUM_REGS = 18,
    parameter logic [6:0]       DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] rd_idx,
    output wr_req_t          wr,
    output logic             sda_low
);
    localparam logic [7:0] SIZE_BYTE = 8'(NUM_REGS);

    tgt_state_t st;
    xfer_ctx_t  ctx;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       rd_dir;
    logic       cnt_pend;
    logic       mack_ok;

    assign rd_idx = ctx.ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ctx      <= '0;
            shreg    <= '0;
            bitcnt   <= '0;
            rd_dir   <= 1'b0;
            cnt_pend <= 1'b0;
            mack_ok  <= 1'b0;
            sda_low  <= 1'b0;
            wr       <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (ev_start) begin
                st      <= S_ADDR;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (ev_stop) begin
                st      <= S_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_CMD, S_CNT, S_WDAT: begin
                        if (ev_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (st)
                                S_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        sda_low <= 1'b1;
                                        rd_dir  <= shreg[0];
                                        st      <= S_ADDR_ACK;
                                    end else begin
                                        st <= S_HOLD;
                                    end
                                end
                                S_CMD: begin
                                    sda_low  <= 1'b1;
                                    ctx.blk  <= ~shreg[7];
                                    ctx.ptr  <= shreg[7] ? shreg[6:0] : '0;
                                    cnt_pend <= ~shreg[7];
                                    st       <= S_CMD_ACK;
                                end
                                S_CNT: begin
                                    sda_low  <= 1'b1;
                                    cnt_pend <= 1'b0;
                                    st       <= S_CNT_ACK;
                                end
                                default: begin
                                    sda_low <= 1'b1;
                                    if (int'(ctx.ptr) < NUM_REGS) begin
                                        wr.stb  <= 1'b1;
                                        wr.idx  <= ctx.ptr;
                                        wr.data <= shreg;
                                    end
                                    ctx.ptr <= ptr_step(ctx.ptr);
                                    st      <= S_WDAT_ACK;
                                end
                            endcase
                        end
                    end
                    S_ADDR_ACK: begin
                        if (ev_fall) begin
                            bitcnt <= '0;
                            if (rd_dir) begin
                                if (cnt_pend) begin
                                    shreg    <= SIZE_BYTE;
                                    sda_low  <= ~SIZE_BYTE[7];
                                    cnt_pend <= 1'b0;
                                end else begin
                                    shreg   <= rd_byte;
                                    sda_low <= ~rd_byte[7];
                                    ctx.ptr <= ptr_step(ctx.ptr);
                                end
                                st <= S_RDAT;
                            end else begin
                                sda_low <= 1'b0;
                                st      <= S_CMD;
                            end
                        end
                    end
                    S_CMD_ACK: begin
                        if (ev_fall) begin
                            sda_low <= 1'b0;
                            st      <= cnt_pend ? S_CNT : S_WDAT;
                        end
                    end
                    S_CNT_ACK, S_WDAT_ACK: begin
                        if (ev_fall) begin
                            sda_low <= 1'b0;
                            st      <= S_WDAT;
                        end
                    end
                    S_RDAT: begin
                        if (ev_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev_fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt  <= '0;
                                sda_low <= 1'b0;
                                st      <= S_RDAT_MACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_low <= ~shreg[6];
                            end
                        end
                    end
                    S_RDAT_MACK: begin
                        if (ev_rise) begin
                            mack_ok <= ~sda_lvl;
                        end else if (ev_fall) begin
                            if (mack_ok) begin
                                shreg   <= rd_byte;
                                sda_low <= ~rd_byte[7];
                                ctx.ptr <= ptr_step(ctx.ptr);
                                st      <= S_RDAT;
                            end else begin
                                st <= S_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: a strobe only ever names an existing register
    assert_strobe_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        wr.stb |-> (int'(wr.idx) < NUM_REGS));

    // R1: no drive while ignoring the bus or idle
    assert_quiet_when_unaddressed_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD || st == S_IDLE) |-> !sda_low);

    // R10: drive only changes while the bus clock is low
    assert_drive_on_low_clock_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !scl_lvl);

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS = 18,
    parameter int STRAP_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STRAP_W-1:0]    strap_in,
    input  logic                  alarm_set,
    input  wr_req_t               wr,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_byte,
    output logic [NUM_REGS*8-1:0] regs_out
);
    localparam int IW = $clog2(NUM_REGS);

    logic [7:0] bank    [NUM_REGS];
    logic [7:0] bank_nx [NUM_REGS];

    always_comb begin
        logic [7:0] ro;
        for (int i = 0; i < NUM_REGS; i++) begin
            bank_nx[i] = bank[i];
            ro         = ro_mask(i);
            if (wr.stb && wr.idx == PTR_W'(i)) begin
                bank_nx[i] = (wr.data & ~ro) | (bank[i] & ro);
                if (i == STAT_REG)
                    bank_nx[i][STAT_BIT] = bank[i][STAT_BIT] & ~wr.data[STAT_BIT];
            end
        end
        if (alarm_set)
            bank_nx[STAT_REG][STAT_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst)
                bank[i] <= reset_value(i) | ((i == STRAP_REG) ? 8'(strap_in) : 8'h00);
            else
                bank[i] <= bank_nx[i];
        end
    end

    assign rd_byte = (int'(rd_idx) < NUM_REGS) ? bank[rd_idx[IW-1:0]] : 8'h00;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_out[g*8 +: 8] = bank[g];
    end

    // R6: identification nibble keeps its value through any write
    assert_ident_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        bank[IDENT_REG][3:0] == 4'h8);

    // R7: status bit only sets after an alarm pulse
    assert_status_set_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bank[STAT_REG][STAT_BIT]) |-> $past(alarm_set));

endmodule

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs
    import smbreg_pkg::*;
#(
    parameter int         NUM_REGS = 18,
    parameter int         STRAP_W  = 5,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    input  logic [STRAP_W-1:0]    strap_in,
    input  logic                  alarm_set,
    output logic                  wr_strobe,
    output logic [PTR_W-1:0]      wr_index,
    output logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_out
);
    logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
    logic [7:0]       rd_byte;
    logic [PTR_W-1:0] rd_idx;
    wr_req_t          wr;

    smb_line_mon u_mon (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    smb_target_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .wr       (wr),
        .sda_low  (sda_pull_low)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .strap_in  (strap_in),
        .alarm_set (alarm_set),
        .wr        (wr),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_byte),
        .regs_out  (regs_out)
    );

    assign wr_strobe = wr.stb;
    assign wr_index  = wr.idx;
    assign wr_data   = wr.data;

endmodule

// File: tb/tb_smb_ctrl_regs.sv
module tb_smb_ctrl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int NREG       = 18;
    localparam logic [4:0] STRAP = 5'b10110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic alarm_set = 1'b0;
    logic sda_pull_low, wr_strobe;
    logic [6:0] wr_index;
    logic [7:0] wr_data;
    logic [NREG*8-1:0] regs_out;
    wire  sda_line = !(m_sda_low || sda_pull_low);

    int n_chk = 0, n_fail = 0, stb_cnt = 0;
    logic [6:0] stb_idx;
    logic [7:0] stb_data;
    logic [7:0] exp_r [NREG];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_ctrl_regs dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .strap_in(STRAP), .alarm_set(alarm_set),
        .wr_strobe(wr_strobe), .wr_index(wr_index), .wr_data(wr_data),
        .regs_out(regs_out)
    );

    always @(negedge clk) if (wr_strobe) begin
        stb_cnt++;
        stb_idx  = wr_index;
        stb_data = wr_data;
    end

    function automatic logic [7:0] dflt(input int i);
        case (i)
            1: return 8'hE0 | {3'b000, STRAP};
            2: return 8'h7F; 3: return 8'hC7; 4: return 8'h17;
            5: return 8'h01; 6: return 8'h08; 8: return 8'h3E;
            15: return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input int i, input logic [7:0] d);
        if (i >= NREG) return;
        if (i == 1)      exp_r[i] = {d[7:5], exp_r[i][4:0]};
        else if (i == 6) exp_r[i] = {d[7:4], 4'h8};
        else if (i == 9) exp_r[i] = {d[7:3], exp_r[i][2] & ~d[2], d[1:0]};
        else             exp_r[i] = d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_file(input string req);
        for (int i = 0; i < NREG; i++)
            chk(regs_out[i*8 +: 8] == exp_r[i], req, regs_out[i*8 +: 8], exp_r[i]);
    endtask

    task automatic tq(); repeat (QTR) @(negedge clk); endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tq(); m_scl = 1'b1; tq();
        m_sda_low = 1'b1; tq(); m_scl = 1'b0; tq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tq(); m_scl = 1'b1; tq(); m_sda_low = 1'b0; tq();
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = !b; tq(); m_scl = 1'b1; tq(); tq(); m_scl = 1'b0; tq();
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; tq(); m_scl = 1'b1; tq(); b = sda_line; tq(); m_scl = 1'b0; tq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackbit);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(ackbit);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(last);
    endtask

    task automatic send_acked(input logic [7:0] b, input string req);
        logic a;
        send_byte(b, a);
        chk(a == 1'b0, req, a, 0);
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
        bus_start();
        send_acked(8'hD2, "R10 addr ack");
        send_acked({1'b1, off}, "R10 cmd ack");
        send_acked(d, "R10 data ack");
        bus_stop();
        model_write(off, d);
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
        bus_start();
        send_acked(8'hD2, "R10 addr ack");
        send_acked({1'b1, off}, "R10 cmd ack");
        bus_start();
        send_acked(8'hD3, "R3 read addr ack");
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        logic [7:0] rd;
        logic a;
        int s0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R9 reset state
        chk_file("R9 reset value");
        chk(sda_pull_low == 1'b0, "R9 line released", sda_pull_low, 0);

        // R1 wrong address: no ack, later bytes ignored
        bus_start();
        send_byte(8'h6A, a); chk(a == 1'b1, "R1 foreign address nack", a, 1);
        send_byte(8'h83, a); chk(a == 1'b1, "R1 ignored byte nack", a, 1);
        send_byte(8'h55, a); chk(a == 1'b1, "R1 ignored byte nack", a, 1);
        bus_stop();
        chk_file("R1 no change");
        chk(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);

        // R2 byte write with strobe
        byte_write(7'd3, 8'hA5);
        chk_file("R2 byte write");
        chk(stb_cnt == 1 && stb_idx == 7'd3 && stb_data == 8'hA5, "R2 strobe",
            {stb_cnt[15:0], 1'b0, stb_idx, stb_data}, {16'd1, 8'h03, 8'hA5});

        // R3 byte read
        byte_read(7'd3, rd); chk(rd == 8'hA5, "R3 read back", rd, 8'hA5);
        byte_read(7'd4, rd); chk(rd == 8'h17, "R3 read default", rd, 8'h17);

        // R6 protected fields
        byte_write(7'd6, 8'hFF); byte_write(7'd1, 8'h00);
        chk_file("R6 protected bits");
        byte_read(7'd6, rd); chk(rd == 8'hF8, "R6 ident nibble", rd, 8'hF8);
        byte_read(7'd1, rd); chk(rd == {3'b000, STRAP}, "R6 strap bits", rd, {3'b000, STRAP});

        // R7 write-one-to-clear status
        @(negedge clk) alarm_set = 1'b1;
        @(negedge clk) alarm_set = 1'b0;
        exp_r[9][2] = 1'b1;
        @(negedge clk);
        chk(regs_out[9*8+2] == 1'b1, "R7 status set", regs_out[9*8+2], 1);
        byte_write(7'd9, 8'h18);
        chk(regs_out[9*8 +: 8] == 8'h1C, "R7 write zero keeps", regs_out[9*8 +: 8], 8'h1C);
        byte_write(7'd9, 8'h04);
        chk(regs_out[9*8 +: 8] == 8'h00, "R7 write one clears", regs_out[9*8 +: 8], 8'h00);
        chk_file("R7 file");

        // R8 out-of-range index
        s0 = stb_cnt;
        byte_write(7'h50, 8'h3C);
        chk(stb_cnt == s0, "R8 no strobe", stb_cnt, s0);
        chk_file("R8 no change");
        byte_read(7'h50, rd); chk(rd == 8'h00, "R8 read zero", rd, 0);
        byte_read(7'd18, rd); chk(rd == 8'h00, "R8 read first beyond", rd, 0);

        // R4 block write, full and truncated
        bus_start();
        send_acked(8'hD2, "R4 addr ack");
        send_acked(8'h00, "R4 cmd ack");
        send_acked(8'h05, "R4 count ack");
        for (int i = 0; i < 5; i++) begin
            logic [7:0] v = 8'($urandom);
            send_acked(v, "R4 data ack");
            model_write(i, v);
        end
        bus_stop();
        chk_file("R4 block write");
        bus_start();
        send_acked(8'hD2, "R4 addr ack");
        send_acked(8'h00, "R4 cmd ack");
        send_acked(8'h05, "R4 count ack");
        send_acked(8'h11, "R4 data ack"); model_write(0, 8'h11);
        send_acked(8'hE2, "R4 data ack"); model_write(1, 8'hE2);
        send_acked(8'h33, "R4 data ack"); model_write(2, 8'h33);
        bus_stop();
        chk_file("R4 early stop");

        // R5 block read
        bus_start();
        send_acked(8'hD2, "R5 addr ack");
        send_acked(8'h00, "R5 cmd ack");
        bus_start();
        send_acked(8'hD3, "R5 read addr ack");
        recv_byte(1'b0, rd); chk(rd == 8'(NREG), "R5 count byte", rd, NREG);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(i == NREG - 1, rd);
            chk(rd == exp_r[i], "R5 block data", rd, exp_r[i]);
        end
        tq();
        chk(sda_pull_low == 1'b0, "R5 released after nack", sda_pull_low, 0);
        bus_stop();

        // random byte writes and reads (R2 R3 R8)
        for (int k = 0; k < 16; k++) begin
            logic [6:0] off = 7'($urandom_range(0, 20));
            logic [7:0] v = 8'($urandom);
            logic [7:0] e;
            s0 = stb_cnt;
            byte_write(off, v);
            chk(stb_cnt == s0 + ((off < NREG) ? 1 : 0), "R2 random strobe count", stb_cnt, s0);
            byte_read(off, rd);
            e = (off < NREG) ? exp_r[off] : 8'h00;
            chk(rd == e, "R3 random read back", rd, e);
        end
        chk_file("R2 final file");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule